// File: doc/BRIEF.md
# Accumulator and Index Add/Subtract Unit

This block is the arithmetic datapath for byte-wide accumulator and word-wide double-accumulator addition and subtraction. It covers the plain forms, the forms that fold the incoming carry flag into the sum or the difference, register-only forms that take the second accumulator as the operand, and the forms that add the second accumulator into an index register. The sequencer supplies the opcode, the register values, a memory operand that has already been fetched and the current carry flag. The block computes the result, names the register that receives it and produces the condition flags. It never writes memory: every result goes to a register.

The block is controlled by a two-state machine. `ST_IDLE` means no result is pending. A `go` pulse moves it to `ST_RESULT` (transition IDLE->RESULT), where `done` is high for the cycle that follows the request. Another `go` keeps it in `ST_RESULT` (RESULT->RESULT). Otherwise it returns to `ST_IDLE` (RESULT->IDLE). The result, destination and flags are registered on the edge that samples `go` and hold until the next request. Multi-precision sums are built by feeding `flag_c` back to `c_flag_in` on the next request.

Top module: `aau_core`

## Requirements
- R1: While `rst_n` is low, and after its release, `result`, `dest`, `done` and all four flags are 0 until the first request.
- R2: When `go` is high at a rising edge, `done` is 1 in the following cycle and the outputs carry that operation. When `go` is low, `done` is 0 and `result`, `dest` and the flags keep their values.
- R3: Opcodes and destinations are: 0 A+M, 1 B+M, 2 D+M, 3 A+M+C, 4 B+M+C, 5 A-M, 6 B-M, 7 D-M, 8 A-M-C, 9 B-M-C, 10 A=A+B, 11 A=A-B, 12 X=X+B, 13 Y=Y+B. Destination codes are 0 none, 1 A, 2 B, 3 D, 4 X, 5 Y. A byte result appears zero-extended in `result`.
- R4: Opcodes 0, 1, 2, 5, 6 and 7 ignore `c_flag_in`.
- R5: Opcodes 3 and 4 add `c_flag_in` into the sum.
- R6: Opcodes 8 and 9 subtract `c_flag_in` from the difference.
- R7: Opcodes 10 and 11 take B as the operand and ignore `mem_opnd`.
- R8: Opcodes 2 and 7 treat {A,B} as one word, with A as the high byte, and take all 16 bits of `mem_opnd` as the operand.
- R9: Opcodes 12 and 13 zero-extend B to 16 bits before adding it and leave all four flags unchanged.
- R10: `flag_c` is the carry out of the MSB for an add, and it is 1 when a subtract borrows.
- R11: `flag_v` is two's complement overflow at the result width. `flag_n` is the result MSB. `flag_z` is 1 exactly when the result is zero.
- R12: Opcodes 14 and 15 give destination 0 and result 0, and leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Operation request, sampled at the rising edge |
| op | input | 4 | Opcode (R3) |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| idx_x | input | 16 | Index register X |
| idx_y | input | 16 | Index register Y |
| mem_opnd | input | 16 | Fetched memory operand; byte forms use bits 7:0 |
| c_flag_in | input | 1 | Current carry flag |
| done | output | 1 | Result valid, one cycle after a request |
| result | output | 16 | Result, zero-extended for byte forms |
| dest | output | 3 | Destination register code |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry or borrow flag |

## Verification
A decode error sends the result to the wrong register, or takes the wrong operand or carry. It shows on `dest` or `result` in the cycle after the request. Wrong flag state, such as index adds that touch the flags, stays on the flag outputs. It is therefore seen on the request that causes it and on every later operation that should have preserved it. Carry chains and near-limit operands are used so that an error in the carry or overflow logic changes a visible bit.

// File: rtl/aau_pkg.sv
package aau_pkg;

    typedef enum logic [3:0] {
        OP_ADDA = 4'd0,  OP_ADDB = 4'd1,  OP_ADDD = 4'd2,
        OP_ADCA = 4'd3,  OP_ADCB = 4'd4,
        OP_SUBA = 4'd5,  OP_SUBB = 4'd6,  OP_SUBD = 4'd7,
        OP_SBCA = 4'd8,  OP_SBCB = 4'd9,
        OP_ABA  = 4'd10, OP_SBA  = 4'd11,
        OP_ABX  = 4'd12, OP_ABY  = 4'd13
    } aau_op_e;

    typedef enum logic [2:0] {
        DST_NONE = 3'd0, DST_A = 3'd1, DST_B = 3'd2,
        DST_D    = 3'd3, DST_X = 3'd4, DST_Y = 3'd5
    } aau_dest_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } aau_state_e;

    typedef struct packed {
        logic      valid;      // defined opcode
        logic      wide;       // word-width arithmetic
        logic      sub;        // subtract
        logic      use_c;      // fold carry flag in
        logic      reg_src;    // operand is accumulator B
        logic      lhs_b;      // byte left operand is B
        logic      idx;        // index plus B form
        logic      upd_flags;  // writes N Z V C
        aau_dest_e dest;
    } aau_ctl_t;

endpackage

// File: rtl/aau_decode.sv
module aau_decode
    import aau_pkg::*;
(
    input  logic [3:0] op,
    output aau_ctl_t   ctl
);
    always_comb begin
        ctl = '{valid: 1'b1, wide: 1'b0, sub: 1'b0, use_c: 1'b0,
                reg_src: 1'b0, lhs_b: 1'b0, idx: 1'b0,
                upd_flags: 1'b1, dest: DST_A};
        case (op)
            OP_ADDA: ;
            OP_ADDB: begin ctl.lhs_b = 1'b1; ctl.dest = DST_B; end
            OP_ADDD: begin ctl.wide = 1'b1; ctl.dest = DST_D; end
            OP_ADCA: ctl.use_c = 1'b1;
            OP_ADCB: begin ctl.use_c = 1'b1; ctl.lhs_b = 1'b1; ctl.dest = DST_B; end
            OP_SUBA: ctl.sub = 1'b1;
            OP_SUBB: begin ctl.sub = 1'b1; ctl.lhs_b = 1'b1; ctl.dest = DST_B; end
            OP_SUBD: begin ctl.sub = 1'b1; ctl.wide = 1'b1; ctl.dest = DST_D; end
            OP_SBCA: begin ctl.sub = 1'b1; ctl.use_c = 1'b1; end
            OP_SBCB: begin
                ctl.sub = 1'b1; ctl.use_c = 1'b1; ctl.lhs_b = 1'b1; ctl.dest = DST_B;
            end
            OP_ABA:  ctl.reg_src = 1'b1;
            OP_SBA:  begin ctl.reg_src = 1'b1; ctl.sub = 1'b1; end
            OP_ABX:  begin
                ctl.wide = 1'b1; ctl.idx = 1'b1; ctl.upd_flags = 1'b0; ctl.dest = DST_X;
            end
            OP_ABY:  begin
                ctl.wide = 1'b1; ctl.idx = 1'b1; ctl.upd_flags = 1'b0; ctl.dest = DST_Y;
            end
            default: begin
                ctl.valid = 1'b0; ctl.upd_flags = 1'b0; ctl.dest = DST_NONE;
            end
        endcase
    end
endmodule

// File: rtl/aau_adder.sv
module aau_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  logic         c_eff,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cy,
    output logic         ov
);
    logic [W-1:0] rhs_x;
    logic         cin_x;
    logic [W:0]   full;

    always_comb begin
        rhs_x = sub ? ~rhs : rhs;
        cin_x = sub ^ c_eff;                    // a - b - c == a + ~b + (1 - c)
        full  = {1'b0, lhs} + {1'b0, rhs_x} + {{W{1'b0}}, cin_x};
        sum   = full[W-1:0];
        cy    = sub ? ~full[W] : full[W];        // borrow is inverted carry
        ov    = (lhs[W-1] == rhs_x[W-1]) && (sum[W-1] != lhs[W-1]);
    end
endmodule

// File: rtl/aau_core.sv
module aau_core
    import aau_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  go,
    input  logic [3:0]            op,
    input  logic [BYTE_W-1:0]     acc_a,
    input  logic [BYTE_W-1:0]     acc_b,
    input  logic [2*BYTE_W-1:0]   idx_x,
    input  logic [2*BYTE_W-1:0]   idx_y,
    input  logic [2*BYTE_W-1:0]   mem_opnd,
    input  logic                  c_flag_in,
    output logic                  done,
    output logic [2*BYTE_W-1:0]   result,
    output logic [2:0]            dest,
    output logic                  flag_n,
    output logic                  flag_z,
    output logic                  flag_v,
    output logic                  flag_c
);
    localparam int WORD_W = 2 * BYTE_W;
    localparam int EXT_W  = WORD_W - BYTE_W;

    aau_ctl_t   ctl;
    aau_state_e state_q, state_d;

    logic [BYTE_W-1:0] b_lhs, b_rhs, b_sum;
    logic [WORD_W-1:0] w_lhs, w_rhs, w_sum, nxt_res;
    logic              b_cy, b_ov, w_cy, w_ov, c_eff;
    logic              nxt_n, nxt_z, nxt_v, nxt_c;
    aau_dest_e         dest_q;

    aau_decode u_dec (.op(op), .ctl(ctl));

    // operand selection
    always_comb begin
        c_eff = ctl.use_c & c_flag_in;
        b_lhs = ctl.lhs_b ? acc_b : acc_a;
        b_rhs = ctl.reg_src ? acc_b : mem_opnd[BYTE_W-1:0];
        if (ctl.idx) begin
            w_lhs = (ctl.dest == DST_X) ? idx_x : idx_y;
            w_rhs = {{EXT_W{1'b0}}, acc_b};
        end else begin
            w_lhs = {acc_a, acc_b};
            w_rhs = mem_opnd;
        end
    end

    aau_adder #(.W(BYTE_W)) u_byte (
        .lhs(b_lhs), .rhs(b_rhs), .c_eff(c_eff), .sub(ctl.sub),
        .sum(b_sum), .cy(b_cy), .ov(b_ov)
    );

    aau_adder #(.W(WORD_W)) u_word (
        .lhs(w_lhs), .rhs(w_rhs), .c_eff(c_eff), .sub(ctl.sub),
        .sum(w_sum), .cy(w_cy), .ov(w_ov)
    );

    always_comb begin
        if (!ctl.valid)   nxt_res = '0;
        else if (ctl.wide) nxt_res = w_sum;
        else              nxt_res = {{EXT_W{1'b0}}, b_sum};
        nxt_n = ctl.wide ? w_sum[WORD_W-1] : b_sum[BYTE_W-1];
        nxt_z = ctl.wide ? (w_sum == '0)   : (b_sum == '0);
        nxt_v = ctl.wide ? w_ov : b_ov;
        nxt_c = ctl.wide ? w_cy : b_cy;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = go ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = go ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
            dest_q <= DST_NONE;
            flag_n <= 1'b0;
            flag_z <= 1'b0;
            flag_v <= 1'b0;
            flag_c <= 1'b0;
        end else if (go) begin
            result <= nxt_res;
            dest_q <= ctl.dest;
            if (ctl.upd_flags) begin
                flag_n <= nxt_n;
                flag_z <= nxt_z;
                flag_v <= nxt_v;
                flag_c <= nxt_c;
            end
        end
    end

    assign done = (state_q == ST_RESULT);
    assign dest = dest_q;

endmodule

// File: rtl/aau_core_chk.sv
module aau_core_chk #(
    parameter int BYTE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                go,
    input logic [3:0]          op,
    input logic                done,
    input logic [2*BYTE_W-1:0] result,
    input logic [2:0]          dest,
    input logic                flag_n,
    input logic                flag_z,
    input logic                flag_v,
    input logic                flag_c
);
    localparam int WORD_W = 2 * BYTE_W;

    p_done_after_go_r2: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> done);

    p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> (!done && $stable(result) && $stable(dest)));

    p_index_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (go && (op == 4'd12 || op == 4'd13)) |=>
            $stable({flag_n, flag_z, flag_v, flag_c}));

    p_reserved_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op >= 4'd14) |=>
            (dest == 3'd0 && result == '0 && $stable({flag_n, flag_z, flag_v, flag_c})));

    p_byte_zext_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (dest == 3'd1 || dest == 3'd2)) |-> (result[WORD_W-1:BYTE_W] == '0));

    p_zero_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dest >= 3'd1 && dest <= 3'd3) |-> (flag_z == (result == '0)));

    p_neg_word_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dest == 3'd3) |-> (flag_n == result[WORD_W-1]));

endmodule

bind aau_core aau_core_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .go(go), .op(op), .done(done),
    .result(result), .dest(dest), .flag_n(flag_n), .flag_z(flag_z),
    .flag_v(flag_v), .flag_c(flag_c)
);

// File: tb/aau_core_test.sv
module aau_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0;
    logic [3:0]  op = '0;
    logic [7:0]  acc_a = '0, acc_b = '0;
    logic [15:0] idx_x = '0, idx_y = '0, mem_opnd = '0;
    logic        c_flag_in = 1'b0;
    logic        done;
    logic [15:0] result;
    logic [2:0]  dest;
    logic        flag_n, flag_z, flag_v, flag_c;

    int n_tests = 0;
    int n_fail  = 0;
    int e_n = 0, e_z = 0, e_v = 0, e_c = 0;   // expected flag state

    always #2.5 clk = ~clk;

    aau_core uut (
        .clk(clk), .rst_n(rst_n), .go(go), .op(op), .acc_a(acc_a), .acc_b(acc_b),
        .idx_x(idx_x), .idx_y(idx_y), .mem_opnd(mem_opnd), .c_flag_in(c_flag_in),
        .done(done), .result(result), .dest(dest),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // reference arithmetic, updates expected flags
    task automatic arith(input int w, input int l, input int r, input int ci,
                         input bit sub, output int res);
        int md, full, sl, sr, sf;
        md   = 1 << w;
        full = sub ? (l - r - ci) : (l + r + ci);
        res  = ((full % md) + md) % md;
        sl   = (l >= md / 2) ? l - md : l;
        sr   = (r >= md / 2) ? r - md : r;
        sf   = sub ? (sl - sr - ci) : (sl + sr + ci);
        e_c  = sub ? int'(full < 0) : int'(full >= md);
        e_v  = int'(sf < -(md / 2) || sf >= md / 2);
        e_n  = int'(res >= md / 2);
        e_z  = int'(res == 0);
    endtask

    task automatic run_op(input string req, input int o, input int a, input int b,
                          input int x, input int y, input int m, input int c);
        int er, ed, ab;
        ab = a * 256 + b;
        case (o)
            0:  begin arith(8, a, m % 256, 0, 0, er); ed = 1; end
            1:  begin arith(8, b, m % 256, 0, 0, er); ed = 2; end
            2:  begin arith(16, ab, m, 0, 0, er); ed = 3; end
            3:  begin arith(8, a, m % 256, c, 0, er); ed = 1; end
            4:  begin arith(8, b, m % 256, c, 0, er); ed = 2; end
            5:  begin arith(8, a, m % 256, 0, 1, er); ed = 1; end
            6:  begin arith(8, b, m % 256, 0, 1, er); ed = 2; end
            7:  begin arith(16, ab, m, 0, 1, er); ed = 3; end
            8:  begin arith(8, a, m % 256, c, 1, er); ed = 1; end
            9:  begin arith(8, b, m % 256, c, 1, er); ed = 2; end
            10: begin arith(8, a, b, 0, 0, er); ed = 1; end
            11: begin arith(8, a, b, 0, 1, er); ed = 1; end
            12: begin er = (x + b) % 65536; ed = 4; end
            13: begin er = (y + b) % 65536; ed = 5; end
            default: begin er = 0; ed = 0; end
        endcase
        @(negedge clk);
        op = 4'(o); acc_a = 8'(a); acc_b = 8'(b); idx_x = 16'(x); idx_y = 16'(y);
        mem_opnd = 16'(m); c_flag_in = c[0]; go = 1'b1;
        @(posedge clk);
        @(negedge clk);
        go = 1'b0;
        check({req, " done"}, int'(done), 1);
        check({req, " result"}, int'(result), er);
        check({req, " dest"}, int'(dest), ed);
        check({req, " flags NZVC"}, int'({flag_n, flag_z, flag_v, flag_c}),
              e_n * 8 + e_z * 4 + e_v * 2 + e_c);
    endtask

    task automatic t_reset();
        check("R1 result", int'(result), 0);
        check("R1 dest", int'(dest), 0);
        check("R1 done", int'(done), 0);
        check("R1 flags", int'({flag_n, flag_z, flag_v, flag_c}), 0);
    endtask

    task automatic t_plain();
        run_op("R4 R11 ADDA overflow c ignored", 0, 'h7F, 0, 0, 0, 'h01, 1);
        run_op("R4 R10 ADDB carry to zero", 1, 0, 'hFF, 0, 0, 'h01, 1);
        run_op("R4 R10 SUBA borrow c ignored", 5, 'h00, 0, 0, 0, 'h01, 1);
        run_op("R4 SUBB", 6, 0, 'h40, 0, 0, 'h10, 1);
    endtask

    task automatic t_carry();
        run_op("R5 ADCA with c", 3, 'h10, 0, 0, 0, 'h20, 1);
        run_op("R5 chain low", 1, 0, 'hFF, 0, 0, 'h01, 0);
        run_op("R5 R10 chain high ADCA", 3, 'h12, 0, 0, 0, 'h00, int'(flag_c));
        run_op("R5 ADCB", 4, 0, 'h7F, 0, 0, 'h00, 1);
    endtask

    task automatic t_borrow();
        run_op("R6 SBCA overflow", 8, 'h80, 0, 0, 0, 'h00, 1);
        run_op("R6 SBCB zero", 9, 0, 'h05, 0, 0, 'h05, 0);
        run_op("R6 R10 SBCB borrow", 9, 0, 'h05, 0, 0, 'h05, 1);
    endtask

    task automatic t_regonly();
        run_op("R7 ABA mem ignored", 10, 'h30, 'h22, 0, 0, 'hFFFF, 1);
        run_op("R7 SBA mem ignored", 11, 'h30, 'h31, 0, 0, 'h5555, 1);
    endtask

    task automatic t_word();
        run_op("R8 ADDD overflow", 2, 'h7F, 'hFF, 0, 0, 'h0001, 1);
        run_op("R8 SUBD borrow", 7, 'h00, 'h00, 0, 0, 'h0001, 1);
        run_op("R8 ADDD cross byte", 2, 'h12, 'hF0, 0, 0, 'h0020, 0);
    endtask

    task automatic t_index();
        run_op("R11 setup flags", 5, 'h00, 0, 0, 0, 'h01, 0);
        run_op("R9 ABX wrap flags kept", 12, 0, 'h20, 'hFFF0, 0, 0, 0);
        run_op("R9 ABY zero extend", 13, 0, 'h80, 0, 'h1234, 0, 1);
    endtask

    task automatic t_reserved();
        run_op("R12 code 14", 14, 'h11, 'h22, 'h3333, 'h4444, 'h5555, 1);
        run_op("R12 code 15", 15, 'hFF, 'hFF, 0, 0, 'hFFFF, 1);
    endtask

    task automatic t_hold();
        int keep_r, keep_d;
        run_op("R2 setup", 0, 'h01, 0, 0, 0, 'h02, 0);
        keep_r = int'(result);
        keep_d = int'(dest);
        @(negedge clk);
        op = 4'd7; acc_a = 8'hAA; mem_opnd = 16'h1234;
        @(negedge clk);
        check("R2 done low when idle", int'(done), 0);
        check("R2 result held", int'(result), keep_r);
        check("R2 dest held", int'(dest), keep_d);
        check("R2 flags held", int'({flag_n, flag_z, flag_v, flag_c}),
              e_n * 8 + e_z * 4 + e_v * 2 + e_c);
    endtask

    initial begin
        #200000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_carry();
        t_borrow();
        t_regonly();
        t_word();
        t_index();
        t_reserved();
        t_hold();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule